// File: doc/BRIEF.md
# Line Access Switch Control Sequencer

This block holds the digital control for a six-pole telephone line access switch. Two mode inputs pick one of four line states: talk, ringing, test or all-off. A latch enable decides when a new mode request is taken. An active-low shutdown line, which an internal thermal-fault flag can also pull low, forces every switch open. A supply-valid flag holds the whole switch in a safe open state during power-up and brown-out.

The ringing switch carries AC ringing current, so it may only open when that current is zero. When the line leaves ringing, whether by a new mode or by shutdown, the ringing return switch opens at once. The ringing switch stays closed until the zero-crossing strobe arrives. A direct change from ringing to talk therefore closes the break pair before the ringing switch opens (make-before-break). Passing through all-off or shutdown first opens the ringing switch before the break pair closes (break-before-make).

A mode request is accepted at one clock edge and reaches the switch enables at the next. Shutdown and supply loss act at the first clock edge.

Top module: `line_switch_ctrl`

## Requirements
- R1: While `supply_ok_i` is low, all four switch enables are 0 from the next clock edge, including the ringing switch. The accepted mode is reset to all-off.
- R2: With `supply_ok_i` high and `latch_i` low, a mode request reaches the enables two clock edges after it is applied.
- R3: After the supply becomes valid with `latch_i` high, all enables stay 0 whatever the mode inputs, until `latch_i` is first driven low.
- R4: Mode {ring,test} = 2'b10 (ringing) gives break 0, ringing return 1, ringing 1, test 0.
- R5: Mode 2'b00 (talk) gives break 1, ringing return 0, test 0, and ringing 0 once any pending release has completed.
- R6: Mode 2'b01 (test) closes only the test pair.
- R7: Mode 2'b11 (all-off) opens every switch, apart from a ringing switch that is still waiting for release.
- R8: When the effective state leaves ringing, the ringing return switch opens at the next edge. The ringing switch stays closed until it sees `zero_cross_i` high at an edge, and then opens at that edge.
- R9: A direct change from ringing to talk closes the break pair while the ringing switch is still closed.
- R10: When `shdn_ext_n_i` is low or `therm_fault_i` is high, break, ringing return and test open at the next edge, and the ringing switch follows R8. `shdn_n_o` shows the combined shutdown line without delay (low means shut down).
- R11: While `latch_i` is high after a mode has been accepted, that mode is held and changes on the mode inputs have no effect.
- R12: If `zero_cross_i` is high in the same cycle that the effective state leaves ringing, the ringing switch opens at the same edge as the ringing return switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Supply above lockout threshold |
| latch_i | input | 1 | Mode acceptance enable, active low (undriven is modelled as 1) |
| mode_ring_i | input | 1 | Ringing select mode bit |
| mode_test_i | input | 1 | Test select mode bit |
| shdn_ext_n_i | input | 1 | External shutdown, active low |
| therm_fault_i | input | 1 | Internal thermal fault, pulls shutdown low |
| zero_cross_i | input | 1 | Ringing-current zero-crossing strobe |
| brk_en_o | output | 1 | Break switch pair enable |
| rret_en_o | output | 1 | Ringing return switch enable |
| ring_en_o | output | 1 | Ringing switch enable |
| test_en_o | output | 1 | Test switch pair enable |
| shdn_n_o | output | 1 | Combined shutdown line state, low means shut down |

## Verification
A zero-crossing strobe can arrive in the same cycle that the effective state leaves ringing. The bench provokes this by raising the thermal fault together with the strobe while the line is ringing. It judges the case by requiring all four enables to be 0 at the next edge (R12). In the other tests the strobe comes several cycles late. There the bench first confirms that the ringing switch stays closed while the break pair is already closed, or while every other switch is open, and only then that it opens on the strobe.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
    // Mode code is {ring_select, test_select}
    typedef enum logic [1:0] {
        LSW_TALK = 2'b00,
        LSW_TEST = 2'b01,
        LSW_RING = 2'b10,
        LSW_OFF  = 2'b11
    } lsw_mode_e;

    typedef struct packed {
        logic brk;
        logic rret;
        logic ring;
        logic test;
    } lsw_sw_s;
endpackage

// File: rtl/lsw_accept.sv
module lsw_accept
    import lsw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      supply_ok_i,
    input  logic      latch_i,
    input  lsw_mode_e mode_req_i,
    output lsw_mode_e mode_o
);
    typedef struct packed {
        lsw_mode_e mode;
    } acc_s;

    acc_s acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (!supply_ok_i) begin
            acc_d.mode = LSW_OFF;
        end else if (!latch_i) begin
            acc_d.mode = mode_req_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '{mode: LSW_OFF};
        else        acc_q <= acc_d;
    end

    assign mode_o = acc_q.mode;

    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && supply_ok_i) |=> $stable(acc_q.mode));

    assert_lockout_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> (acc_q.mode == LSW_OFF));
endmodule

// File: rtl/lsw_drive.sv
module lsw_drive
    import lsw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      supply_ok_i,
    input  logic      shdn_n_i,
    input  lsw_mode_e mode_i,
    input  logic      zero_cross_i,
    output lsw_sw_s   sw_o
);
    lsw_sw_s   sw_d, sw_q;
    lsw_mode_e eff_mode;

    always_comb begin
        eff_mode = shdn_n_i ? mode_i : LSW_OFF;
        sw_d.brk  = (eff_mode == LSW_TALK);
        sw_d.rret = (eff_mode == LSW_RING);
        sw_d.test = (eff_mode == LSW_TEST);
        // Ringing switch may only open at a current zero crossing
        sw_d.ring = (eff_mode == LSW_RING) ? 1'b1 : (sw_q.ring & ~zero_cross_i);
        if (!supply_ok_i) sw_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw_q <= '0;
        else        sw_q <= sw_d;
    end

    assign sw_o = sw_q;

    assert_sw4_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_q.ring && !zero_cross_i && supply_ok_i) |=> sw_q.ring);

    assert_sw4_with_rret_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_q.ring) |-> sw_q.rret);

    assert_override_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n_i |=> !(sw_q.brk || sw_q.rret || sw_q.test));

    assert_one_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_q.brk, sw_q.rret, sw_q.test}));
endmodule

// File: rtl/line_switch_ctrl.sv
module line_switch_ctrl
    import lsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic latch_i,
    input  logic mode_ring_i,
    input  logic mode_test_i,
    input  logic shdn_ext_n_i,
    input  logic therm_fault_i,
    input  logic zero_cross_i,
    output logic brk_en_o,
    output logic rret_en_o,
    output logic ring_en_o,
    output logic test_en_o,
    output logic shdn_n_o
);
    lsw_mode_e mode_req;
    lsw_mode_e mode_acc;
    lsw_sw_s   sw;

    assign mode_req = lsw_mode_e'({mode_ring_i, mode_test_i});
    assign shdn_n_o = shdn_ext_n_i & ~therm_fault_i;

    lsw_accept u_accept (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (supply_ok_i),
        .latch_i     (latch_i),
        .mode_req_i  (mode_req),
        .mode_o      (mode_acc)
    );

    lsw_drive u_drive (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok_i  (supply_ok_i),
        .shdn_n_i     (shdn_n_o),
        .mode_i       (mode_acc),
        .zero_cross_i (zero_cross_i),
        .sw_o         (sw)
    );

    assign brk_en_o  = sw.brk;
    assign rret_en_o = sw.rret;
    assign ring_en_o = sw.ring;
    assign test_en_o = sw.test;

    assert_supply_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> !(brk_en_o || rret_en_o || ring_en_o || test_en_o));
endmodule

// File: tb/line_switch_ctrl_tb.sv
module line_switch_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, latch = 1'b1, m_ring = 1'b1, m_test = 1'b1;
    logic shdn_ext_n = 1'b1, therm = 1'b0, zc = 1'b0;
    logic brk, rret, ring, test, shdn_n;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    line_switch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .latch_i(latch),
        .mode_ring_i(m_ring), .mode_test_i(m_test), .shdn_ext_n_i(shdn_ext_n),
        .therm_fault_i(therm), .zero_cross_i(zc), .brk_en_o(brk), .rret_en_o(rret),
        .ring_en_o(ring), .test_en_o(test), .shdn_n_o(shdn_n)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_sw(input logic [3:0] exp, input string req);
        checks++;
        if ({brk, rret, ring, test} !== exp) begin
            fails++;
            $display("FAIL %s: {brk,rret,ring,test} actual=%b expected=%b", req, {brk, rret, ring, test}, exp);
        end
    endtask

    task automatic check_bit(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic r, input logic t);
        m_ring = r; m_test = t;
    endtask

    task automatic t_reset();
        step(2);
        check_sw(4'b0000, "R1 reset/no supply");
    endtask

    task automatic t_lockout();
        supply_ok = 1'b1; latch = 1'b1; set_mode(1'b0, 1'b0);
        step(4);
        check_sw(4'b0000, "R3 latch high holds all-off");
    endtask

    task automatic t_ring();
        latch = 1'b0; set_mode(1'b1, 1'b0);
        step(2);
        check_sw(4'b0110, "R4 ringing decode (R2 latency)");
    endtask

    task automatic t_mbb();
        set_mode(1'b0, 1'b0);
        step(2);
        check_sw(4'b1010, "R9 make-before-break");
        step(3);
        check_sw(4'b1010, "R8 SW4 waits for strobe");
        zc = 1'b1; step(1); zc = 1'b0;
        check_sw(4'b1000, "R5 talk after strobe");
    endtask

    task automatic t_test_off();
        set_mode(1'b0, 1'b1);
        step(2);
        check_sw(4'b0001, "R6 test decode");
        set_mode(1'b1, 1'b1);
        step(2);
        check_sw(4'b0000, "R7 all-off decode");
    endtask

    task automatic t_hold();
        set_mode(1'b0, 1'b0);
        step(2);
        latch = 1'b1; set_mode(1'b1, 1'b0);
        step(3);
        check_sw(4'b1000, "R11 mode held while latch high");
        latch = 1'b0;
        step(2);
        check_sw(4'b0110, "R11 new mode after latch low");
    endtask

    task automatic t_shdn();
        shdn_ext_n = 1'b0;
        step(1);
        check_sw(4'b0010, "R10 external shutdown, SW4 held");
        check_bit(shdn_n, 1'b0, "R10 shdn_n_o low");
        step(2);
        check_sw(4'b0010, "R8 SW4 held in shutdown");
        zc = 1'b1; step(1); zc = 1'b0;
        check_sw(4'b0000, "R8 SW4 opens on strobe");
        shdn_ext_n = 1'b1;
        step(1);
        check_sw(4'b0110, "R10 release restores ringing");
        check_bit(shdn_n, 1'b1, "R10 shdn_n_o high");
        therm = 1'b1; zc = 1'b1;
        step(1);
        zc = 1'b0;
        check_sw(4'b0000, "R12 strobe coincides with exit");
        check_bit(shdn_n, 1'b0, "R10 thermal fault pulls shutdown");
        therm = 1'b0;
        step(1);
        check_sw(4'b0110, "R10 thermal release");
    endtask

    task automatic t_power();
        supply_ok = 1'b0;
        step(1);
        check_sw(4'b0000, "R1 supply loss forces all off");
        latch = 1'b1;
        supply_ok = 1'b1;
        step(3);
        check_sw(4'b0000, "R3 lockout after supply return");
        latch = 1'b0; set_mode(1'b0, 1'b1);
        step(2);
        check_sw(4'b0001, "R2 accept after latch low");
        supply_ok = 1'b0;
        step(1);
        set_mode(1'b0, 1'b0);
        supply_ok = 1'b1;
        step(2);
        check_sw(4'b1000, "R2 power-up with latch low");
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        t_reset();
        t_lockout();
        t_ring();
        t_mbb();
        t_test_off();
        t_hold();
        t_shdn();
        t_power();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule